// File: doc/BRIEF.md
# SPI flash write-protection controller

This block decides, for a serial flash slave, whether each instruction that could alter stored data or the status register may run. A front-end SPI shifter hands it one decoded instruction event when chip select rises. The event carries the opcode, the 24-bit address, the first status data byte and the number of serial clocks seen during the frame. The controller keeps the write-enable latch, the three block-protect bits, the status-lock bit, a deep power-down flag and a power-up inhibit timer. For every instruction it grants, it emits a one-cycle accept strobe with a kind code and the address.

Instruction events use a valid/ready handshake. `cmd_ready` is high except while a granted program or erase is running. It drops in the cycle after the grant and returns in the cycle after `op_done` is seen. While `cmd_ready` is low, the source must hold the event stable until the handshake completes. The array engine signals that a program or erase has finished with a one-cycle `op_done` pulse. The write-protect pin, the done pulse and the status outputs are plain levels.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset, these outputs are all 0: `wel_o`, `bp_o`, `srwd_o`, `dpd_o` and `acc_o`. `inhibit_o` is 1 and `cmd_ready` is 1.
- R2: `inhibit_o` stays 1 for exactly PUW_CYC rising edges after reset is released, then stays 0. While it is 1, no modifying instruction is granted: write status 0x01, page program 0x02, sector erase 0xD8 or bulk erase 0xC7.
- R3: A modifying instruction is granted only if `cmd_bits` is non-zero and a multiple of eight, which means its low three bits are 0. Otherwise it is dropped and no state changes.
- R4: Write enable (0x06) sets `wel_o`. Write disable (0x04) clears it. A modifying instruction is granted only while `wel_o` is 1.
- R5: A granted write status clears `wel_o` in the same cycle in which it updates the status bits. A granted program or erase leaves `wel_o` set until `op_done`, and clears it then.
- R6: The sector is `cmd_addr[18:16]`. The protected sectors for each `bp_o` value are:
  - 000: none.
  - 001: sector 7.
  - 010: sectors 6 and 7.
  - 011: sectors 4 to 7.
  - 1xx: all sectors.

  A program or sector erase aimed at a protected sector is dropped, and `wel_o` keeps its value.
- R7: Bulk erase is granted only when `bp_o` is 000.
- R8: A granted write status loads `srwd_o` from `cmd_data[7]` and `bp_o` from `cmd_data[4:2]`. Write status is dropped whenever `srwd_o` is 1 and `wprot_n` is 0.
- R9: Deep power-down (0xB9) sets `dpd_o`. While `dpd_o` is 1, every instruction except release (0xAB) leaves all state unchanged. Release clears `dpd_o`.
- R10: Each grant gives `acc_o` high for one cycle, the cycle after the handshake. `acc_kind` is 0 for write status, 1 for page program, 2 for sector erase and 3 for bulk erase. A program or erase grant holds `cmd_ready` low until the cycle after `op_done`.
- R11: An opcode outside the eight listed above changes no state and produces no grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| cmd_valid | input | 1 | Decoded instruction event present |
| cmd_ready | output | 1 | Controller can take an event (low while an operation runs) |
| cmd_opcode | input | 8 | Instruction opcode |
| cmd_addr | input | ADDR_W | Instruction address |
| cmd_data | input | 8 | First data byte (status write value) |
| cmd_bits | input | BITCNT_W | Serial clocks counted while selected |
| wprot_n | input | 1 | Write-protect pin, low = protect |
| op_done | input | 1 | Program/erase finished pulse |
| acc_o | output | 1 | Grant strobe |
| acc_kind | output | 2 | Granted instruction kind |
| acc_addr | output | ADDR_W | Address of the granted instruction |
| wel_o | output | 1 | Write-enable latch |
| bp_o | output | 3 | Block-protect bits |
| srwd_o | output | 1 | Status-lock bit |
| dpd_o | output | 1 | Deep power-down flag |
| inhibit_o | output | 1 | Power-up write inhibit active |

## Verification
Some rules are checked as properties on every cycle:
- No grant may appear unless, in the cycle of the handshake, the latch was set, the timer had expired and the bit count was whole bytes.
- A bulk-erase grant implies that the protect bits are clear.
- Hardware lock and deep power-down keep the protect bits and the latch frozen.
- All-set and all-clear protect values give a full and an empty sector mask.

Other behaviour can only be shown by the bench's scenarios, because it depends on the order of events:
- the exact inhibit length;
- which sectors each protect value covers;
- the latch clearing at completion rather than at grant;
- release from power-down;
- the ready stall across a delayed done pulse.

// File: rtl/fwp_pkg.sv
`timescale 1ns/1ps
package fwp_pkg;
  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_WRSR = 8'h01;
  localparam logic [7:0] OPC_PP   = 8'h02;
  localparam logic [7:0] OPC_SE   = 8'hD8;
  localparam logic [7:0] OPC_BE   = 8'hC7;
  localparam logic [7:0] OPC_DPD  = 8'hB9;
  localparam logic [7:0] OPC_RDP  = 8'hAB;

  typedef enum logic [1:0] {
    ACC_WRSR   = 2'd0,
    ACC_PROG   = 2'd1,
    ACC_SERASE = 2'd2,
    ACC_BERASE = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/fwp_puw_timer.sv
`timescale 1ns/1ps
module fwp_puw_timer #(
  parameter int PUW_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic inhibit_o
);
  localparam int CW = $clog2(PUW_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PUW_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign inhibit_o = (cnt_q != LIMIT);

  // R2
  puw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit_o |=> !inhibit_o);
endmodule

// File: rtl/fwp_region.sv
`timescale 1ns/1ps
module fwp_region #(
  parameter int SECT_W = 3
) (
  input  logic [2:0]              bp_i,
  output logic [(1<<SECT_W)-1:0]  mask_o
);
  localparam int NSECT = 1 << SECT_W;
  localparam logic [SECT_W:0] NSECT_V = (SECT_W+1)'(NSECT);

  logic [SECT_W:0] prot_cnt;
  logic [2:0]      shamt;

  always_comb begin
    shamt = 3'd4 - {1'b0, bp_i[1:0]};
    if (bp_i[2])               prot_cnt = NSECT_V;
    else if (bp_i[1:0] == 2'd0) prot_cnt = '0;
    else                        prot_cnt = NSECT_V >> shamt;
  end

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    assign mask_o[s] = ({1'b0, prot_cnt} + (SECT_W+2)'(s)) >= (SECT_W+2)'(NSECT);
  end
endmodule

// File: rtl/fwp_status_regs.sv
`timescale 1ns/1ps
module fwp_status_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       wr_stat,
  input  logic [2:0] bp_new,
  input  logic       srwd_new,
  input  logic       set_dpd,
  input  logic       clr_dpd,
  input  logic       start_busy,
  input  logic       op_done,
  output logic       wel_q,
  output logic [2:0] bp_q,
  output logic       srwd_q,
  output logic       dpd_q,
  output logic       busy_q
);
  logic finish;
  assign finish = busy_q && op_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      bp_q   <= 3'b000;
      srwd_q <= 1'b0;
      dpd_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (set_wel)               wel_q <= 1'b1;
      else if (clr_wel || finish) wel_q <= 1'b0;
      if (wr_stat) begin
        bp_q   <= bp_new;
        srwd_q <= srwd_new;
      end
      if (set_dpd)      dpd_q <= 1'b1;
      else if (clr_dpd) dpd_q <= 1'b0;
      if (start_busy)   busy_q <= 1'b1;
      else if (finish)  busy_q <= 1'b0;
    end
  end

  // R5
  wel_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && op_done) |=> !wel_q);
endmodule

// File: rtl/flash_wp_ctrl.sv
`timescale 1ns/1ps
module flash_wp_ctrl #(
  parameter int ADDR_W   = 24,
  parameter int BITCNT_W = 16,
  parameter int SECT_LSB = 16,
  parameter int SECT_W   = 3,
  parameter int PUW_CYC  = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [7:0]          cmd_opcode,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [7:0]          cmd_data,
  input  logic [BITCNT_W-1:0] cmd_bits,
  input  logic                wprot_n,
  input  logic                op_done,
  output logic                acc_o,
  output logic [1:0]          acc_kind,
  output logic [ADDR_W-1:0]   acc_addr,
  output logic                wel_o,
  output logic [2:0]          bp_o,
  output logic                srwd_o,
  output logic                dpd_o,
  output logic                inhibit_o
);
  import fwp_pkg::*;

  localparam int NSECT = 1 << SECT_W;

  logic             busy;
  logic [NSECT-1:0] prot_mask;
  logic [SECT_W-1:0] sect;
  logic             hs, byte_ok, mod_ok, hw_lock;
  logic             set_wel, clr_wel, wr_stat, set_dpd, clr_dpd, start_busy, acc_go;
  acc_kind_e        kind_d, kind_q;
  logic             acc_q;
  logic [ADDR_W-1:0] addr_q;
  logic             unused_data;

  assign unused_data = ^{cmd_data[6:5], cmd_data[1:0]};

  fwp_puw_timer #(.PUW_CYC(PUW_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .inhibit_o(inhibit_o)
  );

  fwp_region #(.SECT_W(SECT_W)) u_region (
    .bp_i(bp_o), .mask_o(prot_mask)
  );

  fwp_status_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .set_wel(set_wel), .clr_wel(clr_wel),
    .wr_stat(wr_stat), .bp_new(cmd_data[4:2]), .srwd_new(cmd_data[7]),
    .set_dpd(set_dpd), .clr_dpd(clr_dpd),
    .start_busy(start_busy), .op_done(op_done),
    .wel_q(wel_o), .bp_q(bp_o), .srwd_q(srwd_o), .dpd_q(dpd_o), .busy_q(busy)
  );

  assign cmd_ready = !busy;
  assign hs        = cmd_valid && cmd_ready;
  assign byte_ok   = (cmd_bits[2:0] == 3'd0) && (cmd_bits != '0);
  assign mod_ok    = byte_ok && wel_o && !inhibit_o;
  assign hw_lock   = srwd_o && !wprot_n;
  assign sect      = cmd_addr[SECT_LSB +: SECT_W];

  always_comb begin
    set_wel    = 1'b0;
    clr_wel    = 1'b0;
    wr_stat    = 1'b0;
    set_dpd    = 1'b0;
    clr_dpd    = 1'b0;
    start_busy = 1'b0;
    acc_go     = 1'b0;
    kind_d     = ACC_WRSR;
    if (hs) begin
      if (dpd_o) begin
        if (cmd_opcode == OPC_RDP) clr_dpd = 1'b1;
      end else begin
        case (cmd_opcode)
          OPC_WREN: set_wel = 1'b1;
          OPC_WRDI: clr_wel = 1'b1;
          OPC_DPD:  set_dpd = 1'b1;
          OPC_WRSR: if (mod_ok && !hw_lock) begin
            wr_stat = 1'b1;
            clr_wel = 1'b1;
            acc_go  = 1'b1;
            kind_d  = ACC_WRSR;
          end
          OPC_PP: if (mod_ok && !prot_mask[sect]) begin
            start_busy = 1'b1;
            acc_go     = 1'b1;
            kind_d     = ACC_PROG;
          end
          OPC_SE: if (mod_ok && !prot_mask[sect]) begin
            start_busy = 1'b1;
            acc_go     = 1'b1;
            kind_d     = ACC_SERASE;
          end
          OPC_BE: if (mod_ok && (bp_o == 3'b000)) begin
            start_busy = 1'b1;
            acc_go     = 1'b1;
            kind_d     = ACC_BERASE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      kind_q <= ACC_WRSR;
      addr_q <= '0;
    end else begin
      acc_q <= acc_go;
      if (acc_go) begin
        kind_q <= kind_d;
        addr_q <= cmd_addr;
      end
    end
  end

  assign acc_o    = acc_q;
  assign acc_kind = kind_q;
  assign acc_addr = addr_q;

  // R4
  acc_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |-> $past(wel_o));

  // R2
  acc_after_puw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |-> !$past(inhibit_o));

  // R3
  acc_whole_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o |-> ($past(cmd_bits[2:0]) == 3'd0));

  // R7
  be_unprotected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_o && acc_kind == ACC_BERASE) |-> (bp_o == 3'b000));

  // R8
  hpm_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srwd_o && !wprot_n) |-> ($stable(bp_o) && $stable(srwd_o)));

  // R9
  dpd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dpd_o) && dpd_o) |-> ($stable(wel_o) && $stable(bp_o) && $stable(srwd_o) && !acc_o));

  // R10
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_o && acc_kind != ACC_WRSR) |-> !cmd_ready);

  // R6
  full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bp_o[2] |-> (&prot_mask));

  // R6
  open_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_o == 3'b000) |-> (prot_mask == '0));
endmodule

// File: tb/test_flash_wp_ctrl.sv
`timescale 1ns/1ps
module test_flash_wp_ctrl;
  localparam int PUW = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_opcode = 8'h00;
  logic [23:0] cmd_addr = 24'h0;
  logic [7:0]  cmd_data = 8'h00;
  logic [15:0] cmd_bits = 16'h0;
  logic        wprot_n = 1'b1;
  logic        op_done = 1'b0;
  logic        acc_o;
  logic [1:0]  acc_kind;
  logic [23:0] acc_addr;
  logic        wel_o, srwd_o, dpd_o, inhibit_o;
  logic [2:0]  bp_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic       m_wel = 0, m_srwd = 0, m_dpd = 0;
  logic [2:0] m_bp = 0;

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  flash_wp_ctrl #(.PUW_CYC(PUW)) i_flash_wp_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_bits(cmd_bits), .wprot_n(wprot_n), .op_done(op_done),
    .acc_o(acc_o), .acc_kind(acc_kind), .acc_addr(acc_addr),
    .wel_o(wel_o), .bp_o(bp_o), .srwd_o(srwd_o), .dpd_o(dpd_o),
    .inhibit_o(inhibit_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit prot(input logic [2:0] bp, input logic [2:0] s);
    case (bp)
      3'd0:    return 1'b0;
      3'd1:    return s == 3'd7;
      3'd2:    return s >= 3'd6;
      3'd3:    return s >= 3'd4;
      default: return 1'b1;
    endcase
  endfunction

  task automatic send(input logic [7:0] opc, input logic [23:0] addr,
                      input int bits, input logic [7:0] data, input bit wp, input int dly);
    bit exp_acc, exp_busy, byte_ok, mod_ok, inh;
    int kind;
    exp_acc = 0; exp_busy = 0; kind = 0;
    @(negedge clk);
    cmd_opcode = opc; cmd_addr = addr; cmd_bits = 16'(bits); cmd_data = data;
    wprot_n = wp; cmd_valid = 1'b1;
    inh     = (cyc < PUW);
    byte_ok = (bits % 8 == 0) && (bits != 0);
    mod_ok  = byte_ok && m_wel && !inh;
    if (m_dpd) begin
      if (opc == 8'hAB) m_dpd = 0;          // R9 only release acts
    end else begin
      case (opc)
        8'h06: m_wel = 1;                   // R4
        8'h04: m_wel = 0;                   // R4
        8'hB9: m_dpd = 1;                   // R9
        8'h01: if (mod_ok && !(m_srwd && !wp)) begin   // R8
          m_bp = data[4:2]; m_srwd = data[7]; m_wel = 0; exp_acc = 1; kind = 0;
        end
        8'h02, 8'hD8: if (mod_ok && !prot(m_bp, addr[18:16])) begin  // R6
          exp_acc = 1; exp_busy = 1; kind = (opc == 8'h02) ? 1 : 2;
        end
        8'hC7: if (mod_ok && m_bp == 3'd0) begin       // R7
          exp_acc = 1; exp_busy = 1; kind = 3;
        end
        default: ;                          // R11 unknown opcode
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10", "acc_o", int'(acc_o), int'(exp_acc));
    if (exp_acc) begin
      chk("R10", "acc_kind", int'(acc_kind), kind);
      chk("R10", "acc_addr", int'(acc_addr), int'(addr));
    end
    chk("R4", "wel_o", int'(wel_o), int'(m_wel));
    chk("R8", "bp_o", int'(bp_o), int'(m_bp));
    chk("R8", "srwd_o", int'(srwd_o), int'(m_srwd));
    chk("R9", "dpd_o", int'(dpd_o), int'(m_dpd));
    chk("R2", "inhibit_o", int'(inhibit_o), int'(cyc < PUW));
    chk("R10", "cmd_ready", int'(cmd_ready), int'(!exp_busy));
    if (exp_busy) begin
      repeat (dly) begin
        @(negedge clk);
        chk("R10", "ready held low", int'(cmd_ready), 0);
      end
      op_done = 1'b1;
      @(negedge clk);
      op_done = 1'b0;
      m_wel = 0;
      chk("R5", "wel after done", int'(wel_o), 0);
      chk("R10", "ready after done", int'(cmd_ready), 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    chk("R1", "wel_o", int'(wel_o), 0);
    chk("R1", "bp_o", int'(bp_o), 0);
    chk("R1", "srwd_o", int'(srwd_o), 0);
    chk("R1", "dpd_o", int'(dpd_o), 0);
    chk("R1", "acc_o", int'(acc_o), 0);
    chk("R1", "inhibit_o", int'(inhibit_o), 1);
    chk("R1", "cmd_ready", int'(cmd_ready), 1);

    // R2 modifying instruction refused during inhibit
    send(8'h06, 24'h0, 8, 8'h00, 1, 0);
    send(8'h01, 24'h0, 16, 8'h04, 1, 0);
    while (cyc < PUW - 1) @(negedge clk);
    chk("R2", "inhibit last cycle", int'(inhibit_o), 1);
    @(negedge clk);
    chk("R2", "inhibit expired", int'(inhibit_o), 0);

    // R3 partial byte dropped, then whole bytes accepted
    send(8'h01, 24'h0, 15, 8'h04, 1, 0);
    send(8'h01, 24'h0, 16, 8'h04, 1, 0);
    // R4 no latch -> refused
    send(8'h02, 24'h01_0000, 32, 8'h00, 1, 0);
    // R6 sector 7 protected, sector 6 open
    send(8'h06, 24'h0, 8, 8'h00, 1, 0);
    send(8'h02, 24'h07_0010, 40, 8'h00, 1, 0);
    send(8'h02, 24'h06_0000, 40, 8'h00, 1, 2);
    // R7 bulk erase with bp set
    send(8'h06, 24'h0, 8, 8'h00, 1, 0);
    send(8'hC7, 24'h0, 8, 8'h00, 1, 0);
    // R8 lock bit then pin low
    send(8'h01, 24'h0, 16, 8'h80, 1, 0);
    send(8'h06, 24'h0, 8, 8'h00, 0, 0);
    send(8'h01, 24'h0, 16, 8'h10, 0, 0);
    send(8'h01, 24'h0, 16, 8'h00, 1, 0);
    // R7 bulk erase allowed with bp clear
    send(8'h06, 24'h0, 8, 8'h00, 1, 0);
    send(8'hC7, 24'h0, 8, 8'h00, 1, 3);
    // R9 power-down filtering
    send(8'hB9, 24'h0, 8, 8'h00, 1, 0);
    send(8'h06, 24'h0, 8, 8'h00, 1, 0);
    send(8'hAB, 24'h0, 8, 8'h00, 1, 0);
    // R11 unknown opcode, R4 write disable
    send(8'h06, 24'h0, 8, 8'h00, 1, 0);
    send(8'h9F, 24'h0, 8, 8'h00, 1, 0);
    send(8'h04, 24'h0, 8, 8'h00, 1, 0);

    for (int i = 0; i < 400; i++) begin
      logic [7:0]  opc, data;
      logic [23:0] addr;
      int          bits, r;
      r = int'($urandom % 16);
      case (r)
        0, 1, 2, 3: opc = 8'h06;
        4:          opc = 8'h04;
        5, 6:       opc = 8'h01;
        7, 8, 9:    opc = 8'h02;
        10, 11:     opc = 8'hD8;
        12:         opc = 8'hC7;
        13:         opc = 8'hB9;
        14:         opc = 8'hAB;
        default:    opc = 8'($urandom);
      endcase
      bits = ($urandom % 4 == 0) ? int'($urandom % 40) : 8 * int'(1 + $urandom % 5);
      data = 8'($urandom);
      if ($urandom % 2 == 0) data = data & 8'h83;
      addr = 24'($urandom);
      send(opc, addr, bits, data, ($urandom % 4) != 0, int'($urandom % 4));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule